// File: doc/BRIEF.md
# Row Activation Counter with Neighbour Refresh

This block sits next to a memory controller's command path and protects DRAM against disturbance errors caused by hammering one row with repeated activations (RowHammer). Every activate command the controller issues is also reported here with its bank and row. The block keeps a saturating counter for every row of every bank in a flat register array. The threshold is a runtime input. When an activation pushes a row's count strictly above the threshold, that row's counter returns to zero and the block queues activations of the physically adjacent rows. It offers these on a valid/ready output for the controller to issue.

The neighbour requests are held in a two-entry queue. While the queue holds anything, a stall output tells the controller not to report further activations. An activation presented during stall is dropped rather than counted. A refresh-window pulse zeroes every counter in one cycle. Activations the block requests itself are never fed back into the counters.

Top module: `rh_act_guard`

## Requirements
- R1: After reset, `stall` and `mit_valid` are low and every row counter is zero.
- R2: Each accepted activation adds one to the counter of its own (bank, row) only. No neighbour request is produced while that counter, after the increment, is less than or equal to `thresh`.
- R3: With `thresh` = T, the (T+1)-th counted activation of an interior row r triggers. Two requests in the same bank are then offered: row r-1 first, then row r+1.
- R4: A trigger on row 0 offers only row 1. A trigger on the last row (ROWS-1) offers only row ROWS-2.
- R5: The triggering activation leaves that row's counter at zero, so a further T+1 activations are needed to trigger it again.
- R6: `stall` is high from the cycle after a triggering activation until the queue is empty. An activation presented while `stall` is high is not counted.
- R7: While `mit_valid` is high and `mit_ready` is low, `mit_valid`, `mit_bank` and `mit_row` hold their values.
- R8: A cycle with `window_clear` high leaves every counter at zero. An activation presented in that same cycle is not counted.
- R9: Requests the block issues on the mitigation port do not increment the counter of the row they target.
- R10: A counter at its maximum value (all ones) stays there on further activations. With `thresh` at that maximum, no trigger occurs.
- R11: The comparison uses the value of `thresh` in the cycle of the activation, so lowering `thresh` can make the next activation trigger on a count already accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An activate command was issued this cycle |
| act_bank | input | BW | Bank of the reported activation |
| act_row | input | RW | Row of the reported activation |
| thresh | input | CNT_W | Trigger threshold (strict greater-than) |
| window_clear | input | 1 | Refresh-window pulse; zeroes all counters |
| stall | output | 1 | Neighbour queue is non-empty; do not report activations |
| mit_valid | output | 1 | A neighbour activation request is offered |
| mit_ready | input | 1 | Controller takes the offered request |
| mit_bank | output | BW | Bank of the offered request |
| mit_row | output | RW | Row of the offered request |

## Verification
The assertions assume that `act_bank` stays below BANKS and `act_row` below ROWS whenever `act_valid` is high. They also assume that the controller treats `stall` as a hold, so the queue is only loaded when empty. The stimulus keeps to valid indices and normally waits for `stall` to fall. It breaks that rule only on purpose, to show that activations presented during a stall are dropped. Because those dropped activations never reach the counters, no trigger can arrive while the queue is occupied. `mit_ready` follows an irregular pattern and is sometimes held low for long stretches, so the hold behaviour of the output is exercised.

// File: rtl/rh_guard_pkg.sv
package rh_guard_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2
    } qfill_e;

endpackage

// File: rtl/rh_row_counters.sv
module rh_row_counters #(
    parameter int BANKS = 8,
    parameter int ROWS  = 64,
    parameter int CNT_W = 18,
    localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_valid,
    input  logic [BW-1:0]    inc_bank,
    input  logic [RW-1:0]    inc_row,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clr,
    output logic             trig
);

    localparam int ENTRIES = BANKS * ROWS;
    localparam int IW      = BW + RW;
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [ENTRIES-1:0][CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t          st_d, st_q;
    logic [IW-1:0]    idx;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] bumped;
    logic             any_nonzero;

    assign idx = IW'(inc_bank) * IW'(ROWS) + IW'(inc_row);

    always_comb begin
        st_d   = st_q;
        cur    = st_q.cnt[idx];
        bumped = (cur == CMAX) ? cur : cur + 1'b1;
        trig   = inc_valid && !clr && (bumped > thresh);
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc_valid) begin
            st_d.cnt[idx] = trig ? '0 : bumped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        any_nonzero = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            any_nonzero = any_nonzero | (st_q.cnt[i] != '0);
        end
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_nonzero);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_valid && !clr && (cur == CMAX) && !trig) |=> (st_q.cnt[$past(idx)] == CMAX));

    assert_trig_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (st_q.cnt[$past(idx)] == '0));

endmodule

// File: rtl/rh_neighbor_queue.sv
module rh_neighbor_queue
    import rh_guard_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int ROWS  = 64,
    localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] src_bank,
    input  logic [RW-1:0] src_row,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [BW-1:0] out_bank,
    output logic [RW-1:0] out_row,
    output logic          busy
);

    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    typedef struct packed {
        logic [BW-1:0] bank;
        logic [RW-1:0] row;
    } slot_t;

    typedef struct packed {
        slot_t  s0;
        slot_t  s1;
        qfill_e fill;
    } qstate_t;

    qstate_t st_d, st_q;
    slot_t   lo, hi;
    logic    pop;

    always_comb begin
        st_d    = st_q;
        lo.bank = src_bank;
        lo.row  = src_row - 1'b1;
        hi.bank = src_bank;
        hi.row  = src_row + 1'b1;
        pop     = out_ready && (st_q.fill != Q_EMPTY);
        if (load) begin
            if (src_row == '0) begin
                st_d.s0   = hi;
                st_d.fill = Q_ONE;
            end else if (src_row == LAST) begin
                st_d.s0   = lo;
                st_d.fill = Q_ONE;
            end else begin
                st_d.s0   = lo;
                st_d.s1   = hi;
                st_d.fill = Q_TWO;
            end
        end else if (pop) begin
            st_d.s0   = st_q.s1;
            st_d.fill = (st_q.fill == Q_TWO) ? Q_ONE : Q_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s0   <= '0;
            st_q.s1   <= '0;
            st_q.fill <= Q_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = (st_q.fill != Q_EMPTY);
    assign busy      = out_valid;
    assign out_bank  = st_q.s0.bank;
    assign out_row   = st_q.s0.row;

    assert_load_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (st_q.fill == Q_EMPTY));

    assert_mit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bank) && $stable(out_row)));

    assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_row <= LAST));

endmodule

// File: rtl/rh_act_guard.sv
module rh_act_guard #(
    parameter int BANKS = 8,
    parameter int ROWS  = 64,
    parameter int CNT_W = 18,
    localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [BW-1:0]    act_bank,
    input  logic [RW-1:0]    act_row,
    input  logic [CNT_W-1:0] thresh,
    input  logic             window_clear,
    output logic             stall,
    output logic             mit_valid,
    input  logic             mit_ready,
    output logic [BW-1:0]    mit_bank,
    output logic [RW-1:0]    mit_row
);

    logic accept;
    logic trig;
    logic busy;

    // Activations seen during a stall are dropped, never counted.
    assign accept = act_valid && !busy;
    assign stall  = busy;

    rh_row_counters #(
        .BANKS (BANKS),
        .ROWS  (ROWS),
        .CNT_W (CNT_W)
    ) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (accept),
        .inc_bank  (act_bank),
        .inc_row   (act_row),
        .thresh    (thresh),
        .clr       (window_clear),
        .trig      (trig)
    );

    rh_neighbor_queue #(
        .BANKS (BANKS),
        .ROWS  (ROWS)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trig),
        .src_bank  (act_bank),
        .src_row   (act_row),
        .out_valid (mit_valid),
        .out_ready (mit_ready),
        .out_bank  (mit_bank),
        .out_row   (mit_row),
        .busy      (busy)
    );

    assert_stall_after_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> stall);

    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!stall && !mit_valid));

endmodule

// File: tb/rh_act_guard_test.sv
`timescale 1ns/1ps
module rh_act_guard_test;

    localparam int NB   = 2;
    localparam int NR   = 8;
    localparam int CW   = 6;
    localparam int CMAX = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_valid = 1'b0;
    logic [0:0]    act_bank = '0;
    logic [2:0]    act_row = '0;
    logic [CW-1:0] thresh = 6'd3;
    logic          window_clear = 1'b0;
    logic          stall;
    logic          mit_valid;
    logic          mit_ready = 1'b0;
    logic [0:0]    mit_bank;
    logic [2:0]    mit_row;

    int    vectors = 0;
    int    errs = 0;
    int    expq[$];
    int    model[NB*NR];
    bit    hold_ready = 1'b0;
    int    cyc = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    rh_act_guard #(.BANKS(NB), .ROWS(NR), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
        .act_row(act_row), .thresh(thresh), .window_clear(window_clear),
        .stall(stall), .mit_valid(mit_valid), .mit_ready(mit_ready),
        .mit_bank(mit_bank), .mit_row(mit_row)
    );

    task automatic check(bit ok, string tag, int actv, int expv);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
        end
    endtask

    task automatic do_act(int b, int r);
        int idx;
        int c;
        while (stall) @(negedge clk);
        act_valid = 1'b1;
        act_bank  = b[0:0];
        act_row   = r[2:0];
        idx = b * NR + r;
        c = (model[idx] == CMAX) ? CMAX : model[idx] + 1;
        if (c > int'(thresh)) begin
            if (r > 0)      expq.push_back(b * 16 + r - 1);
            if (r < NR - 1) expq.push_back(b * 16 + r + 1);
            model[idx] = 0;
        end else begin
            model[idx] = c;
        end
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic acts(int b, int r, int n);
        for (int i = 0; i < n; i++) do_act(b, r);
    endtask

    task automatic forced_act(int b, int r);
        act_valid = 1'b1;
        act_bank  = b[0:0];
        act_row   = r[2:0];
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic clear_pulse(bit with_act, int b, int r);
        window_clear = 1'b1;
        if (with_act) begin
            act_valid = 1'b1;
            act_bank  = b[0:0];
            act_row   = r[2:0];
        end
        for (int i = 0; i < NB * NR; i++) model[i] = 0;
        @(negedge clk);
        window_clear = 1'b0;
        act_valid    = 1'b0;
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 200; i++) begin
            if (expq.size() == 0 && !stall && !mit_valid) break;
            @(negedge clk);
        end
        check(expq.size() == 0 && !stall, {tag, " queue drained"}, expq.size(), 0);
    endtask

    // monitor: sets ready for the coming edge, then scores the transfer
    logic [3:0] held;
    bit         pend_hold = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (pend_hold) begin
                check(mit_valid && ({mit_bank, mit_row} == held), "R7 hold while not ready",
                      int'({mit_bank, mit_row}), int'(held));
            end
            mit_ready = !hold_ready && ((cyc % 3) != 1);
            pend_hold = mit_valid && !mit_ready;
            held      = {mit_bank, mit_row};
            if (mit_valid && mit_ready) begin
                int got;
                got = int'(mit_bank) * 16 + int'(mit_row);
                if (expq.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected request"}, got, -1);
                end else begin
                    int e;
                    e = expq.pop_front();
                    check(got == e, {cur_tag, " request order"}, got, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB * NR; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!stall, "R1 stall after reset", int'(stall), 0);
        check(!mit_valid, "R1 mit_valid after reset", int'(mit_valid), 0);

        // R2 / R3: interior row, threshold 3
        cur_tag = "R3";
        acts(0, 3, 3);
        check(!stall, "R2 no trigger at count==thresh", int'(stall), 0);
        do_act(0, 3);
        check(stall, "R6 stall after trigger", int'(stall), 1);
        drain("R3");

        // R5: counter restarted from zero
        cur_tag = "R5";
        acts(0, 3, 3);
        check(!stall, "R5 no early retrigger", int'(stall), 0);
        do_act(0, 3);
        drain("R5");

        // R4: edge rows
        cur_tag = "R4";
        acts(1, 0, 4);
        drain("R4 row0");
        acts(1, 7, 4);
        drain("R4 last row");

        // R9: row 1 of bank 1 was a mitigation target above
        cur_tag = "R9";
        acts(1, 1, 3);
        check(!stall, "R9 mitigation not counted", int'(stall), 0);
        do_act(1, 1);
        drain("R9");

        // R6: activations during stall are dropped
        cur_tag = "R6";
        hold_ready = 1'b1;
        acts(0, 5, 4);
        check(stall, "R6 stall held", int'(stall), 1);
        for (int i = 0; i < 3; i++) forced_act(0, 5);
        hold_ready = 1'b0;
        drain("R6 first");
        acts(0, 5, 3);
        check(!stall, "R6 stalled activations ignored", int'(stall), 0);
        do_act(0, 5);
        drain("R6 second");

        // R8: window clear, alone and together with an activation
        cur_tag = "R8";
        acts(0, 6, 3);
        clear_pulse(1'b0, 0, 0);
        acts(0, 6, 3);
        check(!stall, "R8 counters cleared", int'(stall), 0);
        do_act(0, 6);
        drain("R8 plain");
        acts(0, 6, 2);
        clear_pulse(1'b1, 0, 6);
        acts(0, 6, 3);
        check(!stall, "R8 same-cycle activation dropped", int'(stall), 0);
        do_act(0, 6);
        drain("R8 coincident");

        // R11: lowering the threshold at runtime
        cur_tag = "R11";
        acts(1, 2, 2);
        check(!stall, "R11 below old threshold", int'(stall), 0);
        thresh = 6'd1;
        do_act(1, 2);
        check(stall, "R11 trigger on new threshold", int'(stall), 1);
        drain("R11");

        // R10: saturation at all ones
        cur_tag = "R10";
        thresh = 6'd63;
        acts(0, 1, 70);
        check(!stall, "R10 no trigger at max threshold", int'(stall), 0);
        thresh = 6'd62;
        do_act(0, 1);
        check(stall, "R10 saturated count triggers", int'(stall), 1);
        drain("R10");

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R2 no leftover expectations", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule